// File: doc/BRIEF.md
# Flash Sector Lock Controller

This block keeps one lock bit for every sector of a 134-sector flash array that is addressed in 16-bit words. Every bit comes up locked. Software changes the bits with a short write sequence. Two entry writes open a lock-edit mode. Inside that mode, each further write names one sector and either locks it or unlocks it. A single exit write closes the mode. A write-protect level input can override all the bits at once.

The program and erase engines use the block in two ways. A combinational query port tells whether an address is protected, and it also gives the byte that a protection-status read returns. A request port screens program and erase requests. A request aimed at an unprotected sector is forwarded one cycle later. A request aimed at a protected sector is dropped, and a one-cycle reject pulse is raised instead.

Top module: `sector_guard`

## Requirements
- R1: After reset, every sector reads as protected (qryProt = 1, qryStatus = 01h) while wpN is high.
- R2: Lock-edit mode opens after two consecutive writes whose low data byte is 60h. The address is ignored on both writes, and the upper data byte is ignored on every write. The second entry write changes no lock bit.
- R3: In lock-edit mode, a write with low byte 60h updates the sector its address selects. Address bit 6 high unlocks that sector, and bit 6 low locks it. The query port shows the new value from the cycle after the write.
- R4: Lock-edit mode stays open for any number of sector writes. A write with low byte F0h closes it. After that, a write of 60h is treated as a first entry write and changes no lock bit.
- R5: In lock-edit mode, a write whose low byte is neither 60h nor F0h changes no lock bit and leaves the mode open.
- R6: After the first entry write, any write whose low byte is not 60h cancels the entry. Two new 60h writes are then needed before a sector can be changed.
- R7: While wpN is low, every address reads as protected, whatever the lock bits hold. While wpN is high, the lock bit of the addressed sector decides.
- R8: qryStatus is 01h when the queried address is protected and 00h when it is not.
- R9: Sector selection works as follows. Word addresses 000000h–007FFFh form four 8K-word sectors, selected by address bits 14..13. Word addresses 3F8000h–3FFFFFh form four more 8K-word sectors. Every other 32K-word block, selected by bits 21..15, is one sector. Each sector has its own bit.
- R10: A request that is valid in cycle n gives one of two results in cycle n+1. If the addressed sector is unprotected, fwdValid is 1 and fwdAddr carries the request address. If it is protected, rejPulse is 1 and fwdValid is 0. Both outputs are 0 when no request was made.
- R11: Writes made outside lock-edit mode never change a lock bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; locks every sector |
| wrValid | input | 1 | Write strobe of the command port |
| wrAddr | input | 22 | Word address of the write |
| wrData | input | 16 | Write data; only the low byte is decoded |
| wpN | input | 1 | Write-protect level; low protects every sector |
| qryAddr | input | 22 | Address to check for protection |
| qryProt | output | 1 | The queried address is protected |
| qryStatus | output | 8 | Protection-status byte (01h or 00h) |
| reqValid | input | 1 | Program or erase request strobe |
| reqAddr | input | 22 | Address of the request |
| fwdValid | output | 1 | Request passed on, one cycle after reqValid |
| fwdAddr | output | 22 | Address of the forwarded request |
| rejPulse | output | 1 | One-cycle pulse for a request to a protected sector |

## Verification
The bench attacks the boot regions at both ends of the address space. A decoder that ignored bits 14..13 there, or that was off by one at a region edge, would unlock a neighbouring sector as well, or the wrong one. It checks that the second entry write changes no lock bit even when address bit 6 is high. It also checks that stray data keeps the mode open, and that a cancelled entry really restarts the count. A design that got these wrong would unlock a sector one write too early or refuse the next sector write. Finally, it pulls wpN low with sectors unlocked and sends requests in that state. A design that ignored the pin would report unprotected sectors or forward requests it should have rejected.

// File: rtl/sector_guard_pkg.sv
package sector_guard_pkg;

  // Strobes from the sequence decoder to the lock store
  typedef struct packed {
    logic wrLock;   // update the sector addressed by the current write
    logic lockVal;  // 1 = lock, 0 = unlock
  } lockStrobe_t;

  typedef enum logic [1:0] {
    SEQ_NORMAL = 2'd0,
    SEQ_ARMED  = 2'd1,
    SEQ_OPEN   = 2'd2
  } seqState_t;

endpackage

// File: rtl/sector_guard_ctrl.sv
module sector_guard_ctrl
  import sector_guard_pkg::*;
#(
  parameter int CMD_W = 8,
  parameter logic [CMD_W-1:0] CMD_ENTER = 8'h60,
  parameter logic [CMD_W-1:0] CMD_EXIT  = 8'hF0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic [CMD_W-1:0] wrCmd,
  input  logic             selBit,
  output lockStrobe_t      strobe
);

  seqState_t state, stateNxt;

  always_comb begin
    stateNxt       = state;
    strobe.wrLock  = 1'b0;
    strobe.lockVal = 1'b1;
    if (wrValid) begin
      unique case (state)
        SEQ_NORMAL: begin
          if (wrCmd == CMD_ENTER) stateNxt = SEQ_ARMED;
        end
        SEQ_ARMED: begin
          // second entry write completes the opening; anything else cancels
          stateNxt = (wrCmd == CMD_ENTER) ? SEQ_OPEN : SEQ_NORMAL;
        end
        SEQ_OPEN: begin
          if (wrCmd == CMD_ENTER) begin
            strobe.wrLock  = 1'b1;
            strobe.lockVal = ~selBit;
          end else if (wrCmd == CMD_EXIT) begin
            stateNxt = SEQ_NORMAL;
          end
        end
        default: stateNxt = SEQ_NORMAL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEQ_NORMAL;
    else       state <= stateNxt;
  end

endmodule

// File: rtl/sector_guard_dp.sv
module sector_guard_dp
  import sector_guard_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int BIG_W    = 7,
  parameter int SUB_W    = 2,
  parameter int STATUS_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  lockStrobe_t       strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wpN,
  input  logic [ADDR_W-1:0] qryAddr,
  output logic              qryProt,
  output logic [STATUS_W-1:0] qryStatus,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              fwdValid,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic              rejPulse
);

  localparam int BIG_LSB = ADDR_W - BIG_W;
  localparam int SUB_LSB = BIG_LSB - SUB_W;
  localparam int NBOOT   = 1 << SUB_W;
  localparam int NBIG    = 1 << BIG_W;
  localparam int NSECT   = NBIG - 2 + 2 * NBOOT;
  localparam int SECT_W  = $clog2(NSECT);

  // Map a word address onto its sector number
  function automatic logic [SECT_W-1:0] sectOf(input logic [ADDR_W-1:0] a);
    logic [BIG_W-1:0] big;
    logic [SUB_W-1:0] sub;
    big = a[ADDR_W-1:BIG_LSB];
    sub = a[BIG_LSB-1:SUB_LSB];
    if (big == '0)
      return SECT_W'(sub);
    else if (big == '1)
      return SECT_W'(NBIG - 2 + NBOOT) + SECT_W'(sub);
    else
      return SECT_W'(big) + SECT_W'(NBOOT - 1);
  endfunction

  logic [NSECT-1:0]  lockBits;
  logic [SECT_W-1:0] wrIdx, qIdx, rIdx;
  logic              reqProt;

  assign wrIdx = sectOf(wrAddr);
  assign qIdx  = sectOf(qryAddr);
  assign rIdx  = sectOf(reqAddr);

  for (genvar s = 0; s < NSECT; s++) begin : g_lock
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        lockBits[s] <= 1'b1;
      else if (strobe.wrLock && wrIdx == SECT_W'(s))
        lockBits[s] <= strobe.lockVal;
    end
  end

  assign qryProt   = ~wpN | lockBits[qIdx];
  assign qryStatus = {{(STATUS_W-1){1'b0}}, qryProt};
  assign reqProt   = ~wpN | lockBits[rIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fwdValid <= 1'b0;
      fwdAddr  <= '0;
      rejPulse <= 1'b0;
    end else begin
      fwdValid <= reqValid & ~reqProt;
      rejPulse <= reqValid & reqProt;
      if (reqValid) fwdAddr <= reqAddr;
    end
  end

endmodule

// File: rtl/sector_guard.sv
module sector_guard
  import sector_guard_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int DATA_W   = 16,
  parameter int BIG_W    = 7,
  parameter int SUB_W    = 2,
  parameter int SEL_BIT  = 6,
  parameter int STATUS_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrValid,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                wpN,
  input  logic [ADDR_W-1:0]   qryAddr,
  output logic                qryProt,
  output logic [STATUS_W-1:0] qryStatus,
  input  logic                reqValid,
  input  logic [ADDR_W-1:0]   reqAddr,
  output logic                fwdValid,
  output logic [ADDR_W-1:0]   fwdAddr,
  output logic                rejPulse
);

  localparam int CMD_W = 8;

  lockStrobe_t strobe;

  sector_guard_ctrl #(
    .CMD_W    (CMD_W),
    .CMD_ENTER(8'h60),
    .CMD_EXIT (8'hF0)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .wrValid(wrValid),
    .wrCmd  (wrData[CMD_W-1:0]),
    .selBit (wrAddr[SEL_BIT]),
    .strobe (strobe)
  );

  sector_guard_dp #(
    .ADDR_W  (ADDR_W),
    .BIG_W   (BIG_W),
    .SUB_W   (SUB_W),
    .STATUS_W(STATUS_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrAddr   (wrAddr),
    .wpN      (wpN),
    .qryAddr  (qryAddr),
    .qryProt  (qryProt),
    .qryStatus(qryStatus),
    .reqValid (reqValid),
    .reqAddr  (reqAddr),
    .fwdValid (fwdValid),
    .fwdAddr  (fwdAddr),
    .rejPulse (rejPulse)
  );

endmodule

// File: rtl/sector_guard_chk.sv
module sector_guard_chk #(
  parameter int ADDR_W   = 22,
  parameter int STATUS_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrValid,
  input logic                wpN,
  input logic [ADDR_W-1:0]   qryAddr,
  input logic                qryProt,
  input logic [STATUS_W-1:0] qryStatus,
  input logic                reqValid,
  input logic [ADDR_W-1:0]   reqAddr,
  input logic                fwdValid,
  input logic [ADDR_W-1:0]   fwdAddr,
  input logic                rejPulse
);

  // R1
  reset_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> qryProt);

  // R7
  wp_forces_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wpN |-> qryProt);

  // R8
  status_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (qryStatus == STATUS_W'(0)) || (qryStatus == STATUS_W'(1)));

  // R10
  fwd_rej_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(fwdValid && rejPulse));

  // R10
  rej_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    rejPulse |-> $past(reqValid));

  // R10
  fwd_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> ($past(reqValid) && fwdAddr == $past(reqAddr)));

  // R7
  wp_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(reqValid) && !$past(wpN)) |-> rejPulse);

  // R11
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(wrValid) && $stable(wpN) && $stable(qryAddr)) |-> $stable(qryProt));

endmodule

bind sector_guard sector_guard_chk #(
  .ADDR_W  (ADDR_W),
  .STATUS_W(STATUS_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .wrValid  (wrValid),
  .wpN      (wpN),
  .qryAddr  (qryAddr),
  .qryProt  (qryProt),
  .qryStatus(qryStatus),
  .reqValid (reqValid),
  .reqAddr  (reqAddr),
  .fwdValid (fwdValid),
  .fwdAddr  (fwdAddr),
  .rejPulse (rejPulse)
);

// File: tb/sector_guard_tb_top.sv
module sector_guard_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [21:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        wpN = 1'b1;
  logic [21:0] qryAddr = '0;
  logic        qryProt;
  logic [7:0]  qryStatus;
  logic        reqValid = 1'b0;
  logic [21:0] reqAddr = '0;
  logic        fwdValid;
  logic [21:0] fwdAddr;
  logic        rejPulse;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  bit          modelLock[134];
  int          mode = 0;   // 0 normal, 1 one entry write seen, 2 open
  bit          expFwd = 0;
  bit          expRej = 0;
  logic [21:0] expAddr = '0;

  always #5 clk = ~clk;

  sector_guard dut_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .wpN(wpN), .qryAddr(qryAddr), .qryProt(qryProt), .qryStatus(qryStatus),
    .reqValid(reqValid), .reqAddr(reqAddr), .fwdValid(fwdValid),
    .fwdAddr(fwdAddr), .rejPulse(rejPulse)
  );

  function automatic int idxOf(int a);
    if (a < 'h8000) return a / 'h2000;
    if (a >= 'h3F8000) return 130 + (a - 'h3F8000) / 'h2000;
    return 4 + (a - 'h8000) / 'h8000;
  endfunction

  function automatic bit protOf(int a);
    return !wpN || modelLock[idxOf(a)];
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      foreach (modelLock[i]) modelLock[i] = 1'b1;
      mode = 0; expFwd = 0; expRej = 0;
    end else begin
      expFwd  = reqValid && !protOf(int'(reqAddr));
      expRej  = reqValid && protOf(int'(reqAddr));
      if (reqValid) expAddr = reqAddr;
      if (wrValid) begin
        case (mode)
          0: if (wrData[7:0] == 8'h60) mode = 1;
          1: mode = (wrData[7:0] == 8'h60) ? 2 : 0;
          default: begin
            if (wrData[7:0] == 8'h60) modelLock[idxOf(int'(wrAddr))] = !wrAddr[6];
            else if (wrData[7:0] == 8'hF0) mode = 0;
          end
        endcase
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(qryProt === protOf(int'(qryAddr)), "R7 per-cycle qryProt", 32'(qryProt),
            32'(protOf(int'(qryAddr))));
      check(qryStatus === {7'b0, protOf(int'(qryAddr))}, "R8 per-cycle status",
            32'(qryStatus), 32'(protOf(int'(qryAddr))));
      check(fwdValid === expFwd, "R10 per-cycle fwdValid", 32'(fwdValid), 32'(expFwd));
      check(rejPulse === expRej, "R10 per-cycle rejPulse", 32'(rejPulse), 32'(expRej));
      if (expFwd)
        check(fwdAddr === expAddr, "R10 per-cycle fwdAddr", 32'(fwdAddr), 32'(expAddr));
    end
  end

  task automatic wr(logic [21:0] a, logic [15:0] d);
    @(posedge clk); #2;
    wrValid = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #2;
    wrValid = 1'b0;
  endtask

  task automatic probe(logic [21:0] a, bit expP, string req);
    qryAddr = a;
    #1;
    check(qryProt === expP, req, 32'(qryProt), 32'(expP));
    check(qryStatus === (expP ? 8'h01 : 8'h00), "R8 status byte", 32'(qryStatus),
          expP ? 32'h1 : 32'h0);
  endtask

  task automatic req(logic [21:0] a, bit expPass, string tag);
    @(posedge clk); #2;
    reqValid = 1'b1; reqAddr = a;
    @(posedge clk); #2;
    reqValid = 1'b0;
    check(fwdValid === expPass, tag, 32'(fwdValid), 32'(expPass));
    check(rejPulse === !expPass, tag, 32'(rejPulse), 32'(!expPass));
    if (expPass) check(fwdAddr === a, tag, 32'(fwdAddr), 32'(a));
    @(posedge clk); #2;
    check(rejPulse === 1'b0 && fwdValid === 1'b0, "R10 pulse lasts one cycle",
          32'({fwdValid, rejPulse}), 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    #1;
    // R1: all locked after reset
    probe(22'h000000, 1, "R1 boot sector locked");
    probe(22'h3FFFFF, 1, "R1 top sector locked");
    probe(22'h123456, 1, "R1 large sector locked");

    // R2: entry pair, second write with bit 6 high and a junk upper byte
    wr(22'h000000, 16'h0060);
    wr(22'h008040, 16'hAB60);
    probe(22'h008000, 1, "R2 entry write changes nothing");

    // R3: unlock sector 4
    wr(22'h008040, 16'h0060);
    probe(22'h008000, 0, "R3 unlock");
    probe(22'h010000, 1, "R9 neighbour large sector");

    // R9: boot regions
    wr(22'h002040, 16'h0060);
    probe(22'h002000, 0, "R9 low boot sector 1 unlocked");
    probe(22'h000000, 1, "R9 low boot sector 0 locked");
    probe(22'h004000, 1, "R9 low boot sector 2 locked");
    wr(22'h3FA040, 16'h0060);
    probe(22'h3FA000, 0, "R9 top boot sector 131 unlocked");
    probe(22'h3F8000, 1, "R9 top boot sector 130 locked");
    probe(22'h3FC000, 1, "R9 top boot sector 132 locked");
    probe(22'h3F0000, 1, "R9 last large sector locked");

    // R5: stray data in open mode
    wr(22'h010040, 16'h1234);
    probe(22'h010000, 1, "R5 stray data ignored");
    wr(22'h010040, 16'h0060);
    probe(22'h010000, 0, "R5 mode still open");

    // R3: relock
    wr(22'h008000, 16'h0060);
    probe(22'h008000, 1, "R3 relock");

    // R4: exit then a lone 60h
    wr(22'h000000, 16'h00F0);
    wr(22'h018040, 16'h0060);
    probe(22'h018000, 1, "R4 closed mode ignores sector write");

    // R6: cancel, then full restart needed
    wr(22'h000000, 16'h0000);
    wr(22'h000000, 16'h0060);
    wr(22'h018040, 16'h0060);
    probe(22'h018000, 1, "R6 cancel restarts entry");
    wr(22'h018040, 16'h0060);
    probe(22'h018000, 0, "R6 unlock after full entry");
    wr(22'h000000, 16'h00F0);

    // R11: normal-mode writes
    wr(22'h002000, 16'h0055);
    wr(22'h002000, 16'h00F0);
    wr(22'h018000, 16'h0060);
    probe(22'h002000, 0, "R11 normal writes ignored");
    probe(22'h018000, 0, "R11 lock bit kept");

    // R7: write-protect pin
    wpN = 1'b0;
    probe(22'h002000, 1, "R7 wp low protects unlocked sector");
    probe(22'h3FA000, 1, "R7 wp low protects top boot");
    wpN = 1'b1;
    probe(22'h002000, 0, "R7 wp high restores lock bit");

    // R10: request screening
    req(22'h002000, 1, "R10 unprotected forwarded");
    req(22'h000100, 0, "R10 protected rejected");
    wpN = 1'b0;
    req(22'h3FA000, 0, "R7 wp low rejects request");
    wpN = 1'b1;
    req(22'h018123, 1, "R10 forward after wp release");

    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule